// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block waits for an external parallel NOR flash to finish an internal program or erase cycle. Once a start pulse arrives, it repeatedly reads one status location through a simple request/response read port and examines one status bit in each returned byte. In toggle mode, the operation counts as finished when bit 6 reads the same value on two successive reads. In data-poll mode, it counts as finished when bit 7 of the returned byte equals bit 7 of a supplied expected byte.

A programmable number of idle clock cycles can be placed between reads. Long erase waits use this to spread reads out. A gap of zero gives back-to-back reads. A hard cap on the number of comparison reads keeps a stuck device from hanging the controller. When the run ends, the block pulses `done_o` for one cycle and reports two flags. The timeout flag marks a capped exit. The slow-completion flag marks a run that needed more comparison reads than a second, lower threshold.

Top module: `flash_done_poller`

## Requirements
- R1: After synchronous reset, `rd_req_o`, `busy_o`, `done_o`, `timeout_o` and `warn_o` are all low.
- R2: With `mode_i` = 0 (toggle), the first read only sets a reference bit 6. Every later read is a comparison read. The run completes on the first comparison read whose bit 6 equals the reference. Bits other than bit 6 have no effect.
- R3: In toggle mode, a comparison read whose bit 6 differs from the reference makes that read's bit 6 the new reference.
- R4: With `mode_i` = 1 (data poll), every read is a comparison read, including the first. The run completes when read bit 7 equals bit 7 of `expect_i`, captured at start. All other bits of both bytes are ignored.
- R5: The first read request of a run rises in the cycle after start is taken. Between a returned read and the next request there are exactly `gap_i` idle cycles, with `gap_i` captured at start. With a gap of 0, the next request follows at once.
- R6: If `ITER_CAP` comparison reads have all failed, the run stops. It then pulses `done_o` with `timeout_o` = 1.
- R7: A completion found on the `ITER_CAP`-th comparison read is a normal completion: `timeout_o` = 0.
- R8: `warn_o` is set at the end of a run exactly when the number of comparison reads exceeds `WARN_LIMIT`. `warn_o` and `timeout_o` hold their values until the next accepted start, which clears them.
- R9: `done_o` is high for exactly one cycle. That cycle is the one after the final read data is accepted. `busy_o` is high from the cycle after start until `done_o` rises, and it is low while `done_o` is high.
- R10: A start pulse while `busy_o` is high is ignored. The mode, expected bit, gap and read sequence of the run in progress do not change.
- R11: `rd_req_o` stays high until `rd_valid_i` answers it. A read is consumed only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| mode_i | input | 1 | 0 = toggle test on bit 6, 1 = data-poll test on bit 7 |
| expect_i | input | 8 | Expected data byte; only bit 7 is used |
| gap_i | input | GAP_W | Idle cycles inserted before each re-read |
| rd_req_o | output | 1 | Read request to the flash bus master |
| rd_valid_i | input | 1 | Read data valid, answers `rd_req_o` |
| rd_data_i | input | 8 | Byte read from the flash status location |
| busy_o | output | 1 | Polling run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | Last run ended at the read cap |
| warn_o | output | 1 | Last run needed more than `WARN_LIMIT` comparison reads |

## Verification
Bad state inside the block shows up at the ports as a wrong number of read requests before `done_o`. A stale toggle reference ends a run one or more reads too early or too late. A miscounted iteration counter moves the timeout and slow-completion flags across their thresholds. A faulty gap counter shifts the spacing between successive requests by whole cycles, and this shows on the second read. Each scenario is set up so that its defect changes the read count, the request spacing or the flag values of that same run.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
// Shared types for the completion poller.
// Assumes: one polling run at a time; status bits are bit 6 (toggle) and bit 7 (data).
package fp_pkg;

    // Poll sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_GAP  = 2'd2
    } fp_state_e;

    // Completion test selected at start.
    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } fp_mode_e;

    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned DATA_BIT   = 7;

endpackage

// File: rtl/fp_gap_timer.sv
`timescale 1ns/1ps
// Inter-read gap timer.
// Loads the gap length when a read returns and must be followed by another read.
// Counts down while the sequencer sits in the gap state.
// Assumes the sequencer loads only non-zero lengths.
module fp_gap_timer #(
    parameter int unsigned GAP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GAP_W-1:0] len_i,
    input  logic             run_i,
    output logic             expire_o
);
    localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

    logic [GAP_W-1:0] left_q;

    // Load on a returned read, then count one down per gap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (run_i && left_q != '0) begin
            left_q <= left_q - ONE;
        end
    end

    assign expire_o = run_i && (left_q == ONE);

    // R5
    gap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (left_q != '0));

endmodule

// File: rtl/fp_judge.sv
`timescale 1ns/1ps
// Completion judge.
// Decides, for each accepted read, whether it is a comparison read and whether
// the comparison succeeds. Holds the toggle reference bit, which is refreshed
// on every accepted read.
// Assumes arm_i and take_i are never high in the same cycle.
module fp_judge
    import fp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  fp_mode_e   mode_i,
    input  logic       exp_bit_i,
    input  logic       take_i,
    input  logic [7:0] data_i,
    output logic       is_cmp_o,
    output logic       hit_o
);
    logic first_q;
    logic ref_q;

    // Track the first read of a run and the latest toggle sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            ref_q   <= 1'b0;
        end else if (arm_i) begin
            first_q <= 1'b1;
        end else if (take_i) begin
            first_q <= 1'b0;
            ref_q   <= data_i[TOGGLE_BIT];
        end
    end

    // Comparison qualification and success test for the current read.
    always_comb begin
        is_cmp_o = !((mode_i == MODE_TOGGLE) && first_q);
        if (mode_i == MODE_TOGGLE) begin
            hit_o = (data_i[TOGGLE_BIT] == ref_q);
        end else begin
            hit_o = (data_i[DATA_BIT] == exp_bit_i);
        end
    end

    // R2
    first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !arm_i) |=> !first_q);

endmodule

// File: rtl/fp_iter_count.sv
`timescale 1ns/1ps
// Comparison-read counter.
// Counts failed and final comparison reads of one run. Flags when the
// next read reaches the hard cap and when it passes the warning threshold.
// Assumes inc_i is never raised once the cap is reached (the run ends).
module fp_iter_count #(
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned WARN_LIMIT = 32'h0010_0000,
    parameter int unsigned CNT_W      = $clog2(ITER_CAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o,
    output logic over_o
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(ITER_CAP);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;

    assign nxt = cnt_q + 1'b1;

    // Clear at start, add one per comparison read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= nxt;
        end
    end

    assign last_o = (nxt == CAP_V);
    assign over_o = (32'(nxt) > WARN_LIMIT);

    // R6
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP_V);

endmodule

// File: rtl/flash_done_poller.sv
`timescale 1ns/1ps
// Flash operation completion poller (top).
// Sequences status reads of an external NOR flash after a start pulse. The
// result of each read is judged by the toggle test or the data test, with an
// optional gap between reads, a hard read cap and a slow-completion flag.
// Assumes the read port answers each request eventually and returns status
// bytes from one fixed location.
module flash_done_poller
    import fp_pkg::*;
#(
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned WARN_LIMIT = 32'h0010_0000,
    parameter int unsigned GAP_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [7:0]       expect_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             rd_req_o,
    input  logic             rd_valid_i,
    input  logic [7:0]       rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic             warn_o
);
    localparam int unsigned CNT_W = $clog2(ITER_CAP + 1);

    fp_state_e        state_q, state_d;
    fp_mode_e         mode_q;
    logic             exp_q;
    logic [GAP_W-1:0] gap_q;
    logic             done_q, timeout_q, warn_q;

    logic start_ok, take, finish;
    logic is_cmp, hit, last, over, expire;

    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign take     = (state_q == ST_READ) && rd_valid_i;
    assign finish   = take && is_cmp && (hit || last);

    fp_judge u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (start_ok),
        .mode_i    (mode_q),
        .exp_bit_i (exp_q),
        .take_i    (take),
        .data_i    (rd_data_i),
        .is_cmp_o  (is_cmp),
        .hit_o     (hit)
    );

    fp_iter_count #(
        .ITER_CAP   (ITER_CAP),
        .WARN_LIMIT (WARN_LIMIT),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_ok),
        .inc_i  (take && is_cmp),
        .last_o (last),
        .over_o (over)
    );

    fp_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (take && !finish && (gap_q != '0)),
        .len_i    (gap_q),
        .run_i    (state_q == ST_GAP),
        .expire_o (expire)
    );

    // Next-state selection for the poll sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_READ;
            ST_READ: begin
                if (take) begin
                    if (finish)           state_d = ST_IDLE;
                    else if (gap_q == '0) state_d = ST_READ;
                    else                  state_d = ST_GAP;
                end
            end
            ST_GAP:  if (expire) state_d = ST_READ;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state and run settings captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_TOGGLE;
            exp_q   <= 1'b0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                mode_q <= fp_mode_e'(mode_i);
                exp_q  <= expect_i[DATA_BIT];
                gap_q  <= gap_i;
            end
        end
    end

    // End-of-run pulse and held result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            warn_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (start_ok) begin
                timeout_q <= 1'b0;
                warn_q    <= 1'b0;
            end else if (finish) begin
                timeout_q <= !hit;
                warn_q    <= over;
            end
        end
    end

    assign rd_req_o  = (state_q == ST_READ);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = timeout_q;
    assign warn_o    = warn_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mode_q) && $stable(gap_q)));

    // R5
    zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !finish && (gap_q == '0)) |=> rd_req_o);

endmodule

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the completion poller. A negedge responder model answers
// each read request from a per-test byte script, optionally after stall cycles.
module flash_done_poller_tb_top;

    localparam int unsigned CAP  = 20;
    localparam int unsigned WARN = 8;
    localparam int unsigned GW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [7:0]    expect_i = 8'h00;
    logic [GW-1:0] gap_i = '0;
    logic          rd_req_o;
    logic          rd_valid_i = 1'b0;
    logic [7:0]    rd_data_i = 8'h00;
    logic          busy_o, done_o, timeout_o, warn_o;

    flash_done_poller #(
        .ITER_CAP   (CAP),
        .WARN_LIMIT (WARN),
        .GAP_W      (GW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .expect_i   (expect_i),
        .gap_i      (gap_i),
        .rd_req_o   (rd_req_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .timeout_o  (timeout_o),
        .warn_o     (warn_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Responder state: script written by tasks, counters by the responder.
    logic [7:0] scr [0:63];
    int scr_len   = 1;
    int stall_cfg = 0;
    int stall_left = 0;
    int resp_total = 0;
    int base = 0;
    int stall_seen = 0;
    int rt [0:63];

    // Read responder: answers a pending request at each falling edge.
    always @(negedge clk) begin
        if (rd_req_o && stall_left > 0) begin
            rd_valid_i = 1'b0;
            stall_left = stall_left - 1;
            stall_seen = stall_seen + 1;
        end else if (rd_req_o) begin
            int i;
            i = resp_total - base;
            rd_valid_i = 1'b1;
            rd_data_i  = (i < scr_len) ? scr[i] : scr[scr_len-1];
            if (i < 64) rt[i] = cyc;
            resp_total = resp_total + 1;
            stall_left = stall_cfg;
        end else begin
            rd_valid_i = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Results of the last run.
    int n_reads, start_cyc, done_cyc, done_cnt;
    bit t_out, w_out, busy_after, warn_at_start, pulse_ok;

    // Run one poll. inj > 0 pulses a second start (other settings) while busy.
    task automatic run_poll(input bit m, input logic [7:0] e, input int g,
                            input int stall, input int inj);
        int k;
        @(negedge clk);
        base       = resp_total;
        stall_cfg  = stall;
        stall_left = stall;
        stall_seen = 0;
        mode_i = m; expect_i = e; gap_i = GW'(g);
        start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        busy_after = busy_o;
        warn_at_start = warn_o;
        done_cnt = 0;
        k = 0;
        done_cyc = -1;
        while (done_cyc < 0 && k < 3000) begin
            if (done_o) begin
                done_cyc = cyc;
                done_cnt++;
                t_out = timeout_o;
                w_out = warn_o;
            end else begin
                @(negedge clk);
                k++;
                if (inj > 0 && k == inj) begin
                    start_i = 1'b1; mode_i = !m; expect_i = ~e; gap_i = GW'(0);
                end else begin
                    start_i = 1'b0;
                end
            end
        end
        start_i = 1'b0;
        if (done_cyc < 0) chk(0, "watchdog R9", k, 3000);
        @(negedge clk);
        pulse_ok = !done_o;
        if (done_o) done_cnt++;
        n_reads = resp_total - base;
    endtask

    // Common end-of-run checks.
    task automatic check_run(input string tag, input int exp_reads, input bit exp_t,
                             input bit exp_w, input int g);
        chk(n_reads == exp_reads, {tag, " read count"}, n_reads, exp_reads);
        chk(t_out == exp_t, {tag, " timeout R6"}, t_out, exp_t);
        chk(w_out == exp_w, {tag, " warn R8"}, w_out, exp_w);
        chk(pulse_ok && done_cnt == 1, {tag, " done single pulse R9"}, done_cnt, 1);
        chk(busy_after, {tag, " busy after start R9"}, busy_after, 1);
        if (n_reads >= 1 && n_reads <= 64)
            chk(done_cyc == rt[n_reads-1] + 1, {tag, " done timing R9"},
                done_cyc, rt[n_reads-1] + 1);
        if (g >= 0 && n_reads >= 1) begin
            chk(rt[0] == start_cyc + 1, {tag, " first read no gap R5"}, rt[0], start_cyc + 1);
            for (int i = 1; i < n_reads && i < 64; i++)
                if (rt[i] - rt[i-1] != g + 1)
                    chk(0, {tag, " read spacing R5"}, rt[i] - rt[i-1], g + 1);
        end
    endtask

    task automatic t_reset();
        chk(!rd_req_o && !busy_o && !done_o && !timeout_o && !warn_o, "reset R1",
            {rd_req_o, busy_o, done_o, timeout_o, warn_o}, 0);
    endtask

    // R2 R3: bit 6 sequence 0,1,0,0 with noise in other bits -> 4 reads.
    task automatic t_toggle_ref();
        scr[0] = 8'h05; scr[1] = 8'h4A; scr[2] = 8'h13; scr[3] = 8'hAC; scr_len = 4;
        run_poll(1'b0, 8'h00, 0, 0, 0);
        check_run("toggle reference R3", 4, 0, 0, 0);
    endtask

    // R2: equal bit 6 on first comparison, other bits differ -> 2 reads.
    task automatic t_toggle_fast();
        scr[0] = 8'h40; scr[1] = 8'hFF; scr_len = 2;
        run_poll(1'b0, 8'h00, 2, 0, 0);
        check_run("toggle settle R2", 2, 0, 0, 2);
    endtask

    // R4 R5: data poll on bit 7 only, gap 3 -> 4 reads.
    task automatic t_data_gap();
        scr[0] = 8'h7F; scr[1] = 8'h00; scr[2] = 8'h3C; scr[3] = 8'hC1; scr_len = 4;
        run_poll(1'b1, 8'h85, 3, 0, 0);
        check_run("data poll gap R4", 4, 0, 0, 3);
    endtask

    // R4: first read counts, expected bit 7 = 0.
    task automatic t_data_first();
        scr[0] = 8'h7F; scr_len = 1;
        run_poll(1'b1, 8'h7F, 0, 0, 0);
        check_run("data poll first read R4", 1, 0, 0, 0);
    endtask

    // R6: data poll never matches -> CAP reads, timeout.
    task automatic t_cap_data();
        for (int i = 0; i < 64; i++) scr[i] = 8'h00;
        scr_len = 64;
        run_poll(1'b1, 8'h80, 0, 0, 0);
        check_run("data cap R6", CAP, 1, 1, 0);
    endtask

    // R6: toggle never settles -> CAP+1 reads, timeout.
    task automatic t_cap_toggle();
        for (int i = 0; i < 64; i++) scr[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
        scr_len = 64;
        run_poll(1'b0, 8'h00, 1, 0, 0);
        check_run("toggle cap R6", CAP + 1, 1, 1, 1);
    endtask

    // R7: match on the last allowed comparison read.
    task automatic t_last_match();
        for (int i = 0; i < 64; i++) scr[i] = 8'h00;
        scr[CAP-1] = 8'h80; scr_len = CAP;
        run_poll(1'b1, 8'h80, 0, 0, 0);
        check_run("last read match R7", CAP, 0, 1, 0);
    endtask

    // R8: warn threshold boundary, held flag and clear on next start.
    task automatic t_warn();
        for (int i = 0; i < 64; i++) scr[i] = 8'h00;
        scr[WARN-1] = 8'h80; scr_len = WARN;
        run_poll(1'b1, 8'h80, 0, 0, 0);
        chk(warn_at_start == 0, "warn cleared by start R8", warn_at_start, 0);
        check_run("warn at limit R8", WARN, 0, 0, 0);
        scr[WARN-1] = 8'h00; scr[WARN] = 8'h80; scr_len = WARN + 1;
        run_poll(1'b1, 8'h80, 0, 0, 0);
        check_run("warn above limit R8", WARN + 1, 0, 1, 0);
        repeat (5) @(negedge clk);
        chk(warn_o == 1, "warn held R8", warn_o, 1);
    endtask

    // R11: stalled responses, request must stay up.
    task automatic t_stall();
        scr[0] = 8'h00; scr[1] = 8'h00; scr_len = 2;
        run_poll(1'b0, 8'h00, 0, 3, 0);
        check_run("stall R11", 2, 0, 0, -1);
        chk(stall_seen == 6, "request held during stall R11", stall_seen, 6);
    endtask

    // R10: a start pulse in mid-run changes nothing.
    task automatic t_ignore_start();
        scr[0] = 8'h05; scr[1] = 8'h4A; scr[2] = 8'h13; scr[3] = 8'hAC; scr_len = 4;
        run_poll(1'b0, 8'h00, 3, 0, 3);
        check_run("start ignored R10", 4, 0, 0, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_toggle_ref();
        t_toggle_fast();
        t_data_gap();
        t_data_first();
        t_cap_data();
        t_cap_toggle();
        t_last_match();
        t_warn();
        t_stall();
        t_ignore_start();
        repeat (3) @(negedge clk);
        summary();
    end

    // Global watchdog.
    initial begin
        #(200000 * 20);
        chk(0, "global watchdog", cyc, 0);
        summary();
    end

endmodule